// File: doc/BRIEF.md
# PWM Repetition Counter with Preload Update

This block decides when a three-phase PWM timer may switch to new compare values. Software writes a 13-bit compare value for each phase (U, V, W) into preload registers, and writes an 8-bit repetition value N. The block counts timing intervals from the PWM counter. In edge-aligned mode one interval is a full period. In center-aligned mode one interval is half a period. After N+1 intervals the block raises an update event. On that event it copies all three preloads into the active compare buses, reloads its down-counter from the repetition preload, and sets a sticky update flag.

When the enable bit turns on, the block makes one update at once. This puts the first values in place without waiting for the PWM counter. While the enable bit is low, the block produces no update events and its counter holds. The registers sit on a byte-wide bus that is synchronous to one clock and has combinational read data.

Top module: `pwm_rep_update`

## Requirements
- R1: After reset, every register reads 00h, all three compare outputs are zero and `upd_irq` is low.
- R2: With `center_mode`=0, each `period_pulse` advances the counter and `half_pulse` has no effect. An update follows every N+1 period pulses, where N is the value at address 1.
- R3: With `center_mode`=1, each `half_pulse` advances the counter and `period_pulse` has no effect. An update follows every N+1 half pulses.
- R4: An update copies all three preloads onto `cmp_u`, `cmp_v` and `cmp_w`, and these outputs are visible on the cycle after the update. At any other time the compare outputs hold their values.
- R5: The counter reloads from the repetition preload only at an update. If N is written while counting, the interval already in progress still runs with the old value.
- R6: Writing the control register at address 0 so that bit0 (enable) goes from 0 to 1 causes one update on the following clock. This update transfers the compare values and sets the flag.
- R7: While enable is 0, pulses cause no update, the flag is not set and the compare outputs do not change.
- R8: The control register is laid out as follows. Bit2 is the update flag, which is set by an update and cleared by writing 1. Bit1 is the interrupt enable. `upd_irq` is high only when both the flag and the interrupt enable are set. If an update and a clear happen on the same cycle, the set wins.
- R9: The compare registers are at addresses 2/3 (U), 4/5 (V) and 6/7 (W), with the high byte first. The high byte holds value bits 12:5. Bits 7:3 of the low byte hold value bits 4:0. Bits 2:0 of the low byte read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| center_mode | input | 1 | 1 = count half-period pulses, 0 = count period pulses |
| period_pulse | input | 1 | One-cycle pulse at the end of each PWM period |
| half_pulse | input | 1 | One-cycle pulse at each PWM half period |
| cmp_u | output | 13 | Active compare value, phase U |
| cmp_v | output | 13 | Active compare value, phase V |
| cmp_w | output | 13 | Active compare value, phase W |
| upd_irq | output | 1 | Update interrupt request |

## Verification
A wrong counter state first becomes visible through the timing of the flag. An off-by-one reload or decrement moves the flag by a whole interval, and the next flag read shows this. A lost or spurious transfer shows up on the compare buses one cycle after the update that caused it. A monitor compares each change on those buses against the value sets it expects, in order. Reload errors caused by a mid-run repetition write appear only at the second update after the write, so the checks span two intervals.

// File: rtl/pwm_rep_update.sv
module pwm_rep_update #(
  parameter int REP_W = 8,
  parameter int CMP_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             center_mode,
  input  logic             period_pulse,
  input  logic             half_pulse,
  output logic [CMP_W-1:0] cmp_u,
  output logic [CMP_W-1:0] cmp_v,
  output logic [CMP_W-1:0] cmp_w,
  output logic             upd_irq
);
  localparam int LO_W = CMP_W - 8;

  logic [2:0][CMP_W-1:0] pre, act;
  logic [REP_W-1:0] rep_pre, cnt;
  logic clk_en, en_d, irq_en, flag;

  wire tick   = clk_en & (center_mode ? half_pulse : period_pulse);
  wire en_rise = clk_en & ~en_d;
  wire upd    = en_rise | (tick & (cnt == '0));
  wire clr    = bus_we & (bus_addr == 3'd0) & bus_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; act <= '0; rep_pre <= '0; cnt <= '0;
      clk_en <= 1'b0; en_d <= 1'b0; irq_en <= 1'b0; flag <= 1'b0;
    end else begin
      en_d <= clk_en;
      if (bus_we) begin
        if (bus_addr == 3'd0) begin
          clk_en <= bus_wdata[0];
          irq_en <= bus_wdata[1];
        end
        if (bus_addr == 3'd1) rep_pre <= bus_wdata[REP_W-1:0];
        for (int i = 0; i < 3; i++) begin
          if (bus_addr == 3'(2 + 2*i)) pre[i][CMP_W-1:LO_W] <= bus_wdata;
          if (bus_addr == 3'(3 + 2*i)) pre[i][LO_W-1:0] <= bus_wdata[7 -: LO_W];
        end
      end
      if (upd) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (upd) begin
        cnt <= rep_pre;
        act <= pre;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata = {5'b0, flag, irq_en, clk_en};
      3'd1: bus_rdata = 8'(rep_pre);
      3'd2: bus_rdata = pre[0][CMP_W-1:LO_W];
      3'd3: bus_rdata = {pre[0][LO_W-1:0], {(8-LO_W){1'b0}}};
      3'd4: bus_rdata = pre[1][CMP_W-1:LO_W];
      3'd5: bus_rdata = {pre[1][LO_W-1:0], {(8-LO_W){1'b0}}};
      3'd6: bus_rdata = pre[2][CMP_W-1:LO_W];
      default: bus_rdata = {pre[2][LO_W-1:0], {(8-LO_W){1'b0}}};
    endcase
  end

  assign cmp_u = act[0];
  assign cmp_v = act[1];
  assign cmp_w = act[2];
  assign upd_irq = flag & irq_en;

  p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({cmp_u, cmp_v, cmp_w}));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> cnt == $past(rep_pre));
  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !en_rise) |=> cnt == $past(cnt) - 1'b1);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(cnt) && $stable({cmp_u, cmp_v, cmp_w}));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> flag);
endmodule

// File: tb/pwm_rep_update_tb.sv
module pwm_rep_update_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] bus_addr = 0;
  logic bus_we = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic center_mode = 0, period_pulse = 0, half_pulse = 0;
  logic [12:0] cmp_u, cmp_v, cmp_w;
  logic upd_irq;
  int checks = 0, errors = 0;
  logic [38:0] exp_q[$];
  logic [38:0] last_cmp = '0;
  logic [12:0] pu, pv, pw;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_rep_update u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic flag_is(string req, logic e);
    logic [7:0] d;
    rd(3'd0, d);
    chk(req, d[2], e);
  endtask

  task automatic pulse(bit half);
    @(negedge clk);
    if (half) half_pulse = 1; else period_pulse = 1;
    @(negedge clk); half_pulse = 0; period_pulse = 0;
  endtask

  task automatic load(logic [12:0] u, logic [12:0] v, logic [12:0] w);
    wr(3'd2, u[12:5]); wr(3'd3, {u[4:0], 3'b111});
    wr(3'd4, v[12:5]); wr(3'd5, {v[4:0], 3'b101});
    wr(3'd6, w[12:5]); wr(3'd7, {w[4:0], 3'b010});
    exp_q.push_back({u, v, w});
  endtask

  // monitor: each change of the compare buses must match the next queued set
  always @(negedge clk) if (rst_n && !done) begin
    if ({cmp_u, cmp_v, cmp_w} !== last_cmp) begin
      last_cmp = {cmp_u, cmp_v, cmp_w};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: unexpected compare change actual %0h expected none", last_cmp);
      end else begin
        logic [38:0] e;
        e = exp_q.pop_front();
        if (e !== last_cmp) begin
          errors++;
          $display("FAIL R4: compare transfer actual %0h expected %0h", last_cmp, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin rd(3'(a), d); chk("R1", d, 0); end
    chk("R1", {cmp_u, cmp_v, cmp_w}, 0);
    chk("R1", upd_irq, 0);

    // R9 layout and reserved bits
    load(13'h1ABC, 13'h0F35, 13'h1001);
    rd(3'd2, d); chk("R9", d, 8'hD5);
    rd(3'd3, d); chk("R9", d, 8'hE0);
    rd(3'd5, d); chk("R9", d, 8'hA8);
    rd(3'd7, d); chk("R9", d, 8'h08);

    // R7 disabled: pulses do nothing
    wr(3'd1, 8'd2);
    pulse(0); pulse(1); pulse(0);
    flag_is("R7", 0);
    chk("R7", cmp_u, 0);

    // R6 enable rising: immediate update
    wr(3'd0, 8'b011);
    @(negedge clk);
    flag_is("R6", 1);
    chk("R6", cmp_u, 13'h1ABC);
    chk("R8", upd_irq, 1);
    wr(3'd0, 8'b111);
    flag_is("R8", 0);
    chk("R8", upd_irq, 0);

    // R2 edge-aligned, N=2: half pulses ignored
    pulse(0); pulse(0);
    flag_is("R2", 0);
    pulse(1); pulse(1);
    flag_is("R2", 0);
    load(13'h0123, 13'h1FFF, 13'h0000);
    pulse(0);
    flag_is("R2", 1);

    // R5 mid-run repetition write
    wr(3'd0, 8'b111);
    wr(3'd1, 8'd0);
    pulse(0); pulse(0);
    flag_is("R5", 0);
    pulse(0);
    flag_is("R5", 1);
    wr(3'd0, 8'b111);
    pulse(0);
    flag_is("R5", 1);

    // R3 center-aligned, N=1
    center_mode = 1;
    wr(3'd1, 8'd1);
    wr(3'd0, 8'b111);
    pulse(0);
    flag_is("R3", 0);
    pulse(1);
    flag_is("R3", 1);
    wr(3'd0, 8'b111);
    pulse(1); pulse(0);
    flag_is("R3", 0);
    load(13'h0AAA, 13'h1555, 13'h0777);
    pulse(1);
    flag_is("R3", 1);

    // R8 interrupt gating
    wr(3'd0, 8'b101);
    pulse(1); pulse(1);
    flag_is("R8", 1);
    chk("R8", upd_irq, 0);
    wr(3'd0, 8'b011);
    @(negedge clk);
    chk("R8", upd_irq, 1);

    // R7 disable, then R6 re-enable
    wr(3'd0, 8'b100);
    wr(3'd2, 8'h11);
    pulse(1); pulse(1); pulse(1);
    flag_is("R7", 0);
    chk("R7", cmp_u, 13'h0AAA);
    pu = 13'h0AAA; pu[12:5] = 8'h11;
    exp_q.push_back({pu, 13'h1555, 13'h0777});
    wr(3'd0, 8'b011);
    @(negedge clk);
    flag_is("R6", 1);
    chk("R6", cmp_u, pu);

    repeat (2) @(negedge clk);
    chk("R4", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule